// File: doc/BRIEF.md
# Two-Channel DMA Channel Status Sequencer

This block keeps the status of two DMA channels and decides which one may drive the transfer engine. Software writes one-cycle command strobes per channel: start, stop and clear. The transfer engine reports four things per channel: that the last access of the job is done, that accesses are still in flight, and any internal or external address fault. Only one channel runs at a time. A channel that is started while the other is busy waits in a Queued state. It takes over on its own once the other channel releases the engine.

For each channel the block drives a 3-bit status code, a run-enable for the engine, a halt request that asks the engine to stop early, and two sticky fault flags. A channel that ends with a fault keeps its claim on the engine until software clears it. This stops a queued job from running behind a failed one unnoticed.

Top module: `dma_chan_seq`

## Requirements
- R1: Status is 3 bits per channel, channel 0 in `status_o[2:0]` and channel 1 in `status_o[5:3]`, coded Idle=0, Queued=1, Running=2, Complete=3, Error=4. After reset both channels are Idle and all run-enable, halt and fault outputs are 0.
- R2: A start on an Idle channel moves it to Running on the next clock edge when the other channel is not in operation, and to Queued when it is. A start on a channel that is not Idle has no effect.
- R3: A channel is in operation when it is Queued, Running, or Complete/Error with a fault flag set. At most one channel is Running at any time. A channel that is Complete with no fault flag does not block the other channel.
- R4: A stop on a Running channel sets its halt request and clears its run-enable from the next edge. The status stays Running while `outstanding_i` is 1. Once `outstanding_i` is 0, the channel goes to Complete, or to Error if a fault flag is set.
- R5: A stop on a Queued channel returns it to Idle on the next edge. A stop in Idle, Complete or Error has no effect.
- R6: A clear on a Complete or Error channel returns it to Idle and resets both of its fault flags. A clear in any other state has no effect.
- R7: While Running, a 1 on `int_err_i` or `ext_err_i` sets the matching sticky flag. When `last_done_i` is 1 and `outstanding_i` is 0, the channel finishes as Complete if no flag is set and as Error otherwise.
- R8: A Queued channel becomes Running on the edge one cycle after the other channel stops being in operation. When both channels would enter Running on the same edge, channel 0 does and channel 1 goes to or stays in Queued.
- R9: When several strobes for one channel arrive in the same cycle, only the highest-priority one is acted on, in the order clear, stop, start. The others are discarded, even when the chosen strobe has no effect in the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 2 | Per-channel start strobe |
| stop_i | input | 2 | Per-channel stop strobe |
| clear_i | input | 2 | Per-channel clear strobe |
| last_done_i | input | 2 | Engine reports the final access of the job has completed |
| outstanding_i | input | 2 | Engine has accesses still in flight |
| int_err_i | input | 2 | Internal address fault reported this cycle |
| ext_err_i | input | 2 | External address fault reported this cycle |
| status_o | output | 6 | Per-channel 3-bit status code |
| run_en_o | output | 2 | Channel may issue new accesses |
| halt_req_o | output | 2 | Engine is asked to stop issuing and drain |
| int_err_o | output | 2 | Sticky internal fault flag |
| ext_err_o | output | 2 | Sticky external fault flag |

## Verification
The bench sweeps all eight strobe combinations on channel 0 from each of its five states. A wrong priority order, or a strobe honoured in the wrong state, would show up as a stray move to Running, Idle or Queued. Stop is held against a busy engine: a design that leaves Running before the drain ends would report Complete too early. A faulted finished channel is checked to hold off a start on the other channel, which an in-operation test that forgets the fault flags would wave through to Running. Same-edge starts and the promotion edge are timed cycle by cycle, which catches both a lost channel-0 priority and a promotion one cycle early or late.

// File: rtl/dma_seq_pkg.sv
// Shared types for the DMA channel sequencer: status codes and resolved commands.
package dma_seq_pkg;
    localparam int CH_CNT = 2;
    localparam int ST_W   = 3;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE   = 3'd0,
        ST_QUEUED = 3'd1,
        ST_RUN    = 3'd2,
        ST_DONE   = 3'd3,
        ST_FAULT  = 3'd4
    } chan_st_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_START,
        CMD_STOP,
        CMD_CLEAR
    } chan_cmd_e;
endpackage

// File: rtl/dma_cmd_prio.sv
// Reduces the three command strobes of one channel to a single command.
// Assumes strobes are one-cycle pulses; clear beats stop, stop beats start.
module dma_cmd_prio
    import dma_seq_pkg::*;
(
    input  logic      start_i,
    input  logic      stop_i,
    input  logic      clear_i,
    output chan_cmd_e cmd_o
);
    // Fixed-priority pick of one strobe.
    always_comb begin
        if (clear_i)      cmd_o = CMD_CLEAR;
        else if (stop_i)  cmd_o = CMD_STOP;
        else if (start_i) cmd_o = CMD_START;
        else              cmd_o = CMD_NONE;
    end
endmodule

// File: rtl/dma_bus_arb.sv
// Decides which channel may enter Running this cycle.
// A start needs every other channel out of operation. A queued channel only
// needs every other channel to stop holding the engine. Lower index wins ties.
module dma_bus_arb
    import dma_seq_pkg::*;
#(
    parameter int N_CH = CH_CNT
) (
    input  chan_st_e          st_i    [N_CH],
    input  logic [N_CH-1:0]   fault_i,
    input  chan_cmd_e         cmd_i   [N_CH],
    output logic [N_CH-1:0]   grant_o
);
    logic [N_CH-1:0] holds;
    logic [N_CH-1:0] in_op;

    // Classify each channel as holding the engine and/or in operation.
    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            holds[i] = (st_i[i] == ST_RUN) ||
                       (((st_i[i] == ST_DONE) || (st_i[i] == ST_FAULT)) && fault_i[i]);
            in_op[i] = holds[i] || (st_i[i] == ST_QUEUED);
        end
    end

    // Fixed-priority grant over channels that want to run.
    always_comb begin
        logic lower_won;
        logic oth_op;
        logic oth_hold;
        lower_won = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            oth_op   = |(in_op & ~(N_CH'(1) << i));
            oth_hold = |(holds & ~(N_CH'(1) << i));
            grant_o[i] = !lower_won &&
                (((cmd_i[i] == CMD_START) && (st_i[i] == ST_IDLE) && !oth_op) ||
                 ((st_i[i] == ST_QUEUED) && (cmd_i[i] != CMD_STOP) && !oth_hold));
            lower_won = lower_won || grant_o[i];
        end
    end
endmodule

// File: rtl/dma_chan_fsm.sv
// Status state machine of one channel.
// Assumes the arbiter grant is only raised for an Idle channel being started
// or a Queued channel; fault inputs are only sampled while Running.
module dma_chan_fsm
    import dma_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cmd_e cmd_i,
    input  logic      grant_i,
    input  logic      last_done_i,
    input  logic      outstanding_i,
    input  logic      int_err_i,
    input  logic      ext_err_i,
    output chan_st_e  st_o,
    output logic      halt_o,
    output logic      run_en_o,
    output logic      int_flag_o,
    output logic      ext_flag_o
);
    chan_st_e st_q, st_d;
    logic     halt_q, halt_d;
    logic     int_q, int_d;
    logic     ext_q, ext_d;
    logic     drained;

    // Running job ends once the engine is empty after a halt or the final access.
    assign drained = (halt_q || last_done_i) && !outstanding_i;

    // Next-state and flag logic.
    always_comb begin
        st_d   = st_q;
        halt_d = halt_q;
        int_d  = int_q;
        ext_d  = ext_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_i == CMD_START) st_d = grant_i ? ST_RUN : ST_QUEUED;
            end
            ST_QUEUED: begin
                if (cmd_i == CMD_STOP) st_d = ST_IDLE;
                else if (grant_i)      st_d = ST_RUN;
            end
            ST_RUN: begin
                int_d = int_q || int_err_i;
                ext_d = ext_q || ext_err_i;
                if (drained) begin
                    st_d   = (int_d || ext_d) ? ST_FAULT : ST_DONE;
                    halt_d = 1'b0;
                end else if (cmd_i == CMD_STOP) begin
                    halt_d = 1'b1;
                end
            end
            ST_DONE, ST_FAULT: begin
                if (cmd_i == CMD_CLEAR) begin
                    st_d  = ST_IDLE;
                    int_d = 1'b0;
                    ext_d = 1'b0;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            halt_q <= 1'b0;
            int_q  <= 1'b0;
            ext_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            halt_q <= halt_d;
            int_q  <= int_d;
            ext_q  <= ext_d;
        end
    end

    assign st_o       = st_q;
    assign halt_o     = halt_q;
    assign run_en_o   = (st_q == ST_RUN) && !halt_q;
    assign int_flag_o = int_q;
    assign ext_flag_o = ext_q;
endmodule

// File: rtl/dma_chan_seq.sv
// Top of the two-channel DMA status sequencer: per-channel command priority,
// shared arbiter and per-channel state machines.
// Assumes command strobes are single-cycle and synchronous to clk.
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int N_CH = CH_CNT,
    localparam int SW  = ST_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CH-1:0]    start_i,
    input  logic [N_CH-1:0]    stop_i,
    input  logic [N_CH-1:0]    clear_i,
    input  logic [N_CH-1:0]    last_done_i,
    input  logic [N_CH-1:0]    outstanding_i,
    input  logic [N_CH-1:0]    int_err_i,
    input  logic [N_CH-1:0]    ext_err_i,
    output logic [N_CH*SW-1:0] status_o,
    output logic [N_CH-1:0]    run_en_o,
    output logic [N_CH-1:0]    halt_req_o,
    output logic [N_CH-1:0]    int_err_o,
    output logic [N_CH-1:0]    ext_err_o
);
    chan_cmd_e       cmd   [N_CH];
    chan_st_e        st    [N_CH];
    logic [N_CH-1:0] grant;
    logic [N_CH-1:0] fault;

    // Any sticky fault per channel, seen by the arbiter.
    assign fault = int_err_o | ext_err_o;

    dma_bus_arb #(.N_CH(N_CH)) u_arb (
        .st_i    (st),
        .fault_i (fault),
        .cmd_i   (cmd),
        .grant_o (grant)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        dma_cmd_prio u_prio (
            .start_i (start_i[g]),
            .stop_i  (stop_i[g]),
            .clear_i (clear_i[g]),
            .cmd_o   (cmd[g])
        );

        dma_chan_fsm u_fsm (
            .clk           (clk),
            .rst_n         (rst_n),
            .cmd_i         (cmd[g]),
            .grant_i       (grant[g]),
            .last_done_i   (last_done_i[g]),
            .outstanding_i (outstanding_i[g]),
            .int_err_i     (int_err_i[g]),
            .ext_err_i     (ext_err_i[g]),
            .st_o          (st[g]),
            .halt_o        (halt_req_o[g]),
            .run_en_o      (run_en_o[g]),
            .int_flag_o    (int_err_o[g]),
            .ext_flag_o    (ext_err_o[g])
        );

        assign status_o[g*SW +: SW] = st[g];
    end
endmodule

// File: rtl/dma_chan_seq_chk.sv
// Property checker for dma_chan_seq, attached by bind.
// Assumes the default two-channel configuration.
module dma_chan_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] start_i,
    input logic [1:0] stop_i,
    input logic [1:0] clear_i,
    input logic [1:0] last_done_i,
    input logic [1:0] outstanding_i,
    input logic [1:0] int_err_i,
    input logic [1:0] ext_err_i,
    input logic [5:0] status_o,
    input logic [1:0] run_en_o,
    input logic [1:0] halt_req_o,
    input logic [1:0] int_err_o,
    input logic [1:0] ext_err_o
);
    AST_NEVER_TWO_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        !((status_o[2:0] == 3'd2) && (status_o[5:3] == 3'd2))); // R3

    for (genvar g = 0; g < 2; g++) begin : g_chk
        AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            status_o[g*3 +: 3] <= 3'd4); // R1

        AST_RUN_EN_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
            run_en_o[g] |-> (status_o[g*3 +: 3] == 3'd2) && !halt_req_o[g]); // R4

        AST_HALT_WAITS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
            (halt_req_o[g] && outstanding_i[g]) |=> (status_o[g*3 +: 3] == 3'd2)); // R4

        AST_QUEUED_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            ((status_o[g*3 +: 3] == 3'd1) && stop_i[g] && !clear_i[g])
            |=> (status_o[g*3 +: 3] == 3'd0)); // R5

        AST_CLEAR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            ((status_o[g*3 +: 3] >= 3'd3) && clear_i[g])
            |=> (status_o[g*3 +: 3] == 3'd0) && !int_err_o[g] && !ext_err_o[g]); // R6

        AST_FINISHED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            ((status_o[g*3 +: 3] >= 3'd3) && !clear_i[g])
            |=> $stable(status_o[g*3 +: 3])); // R2
    end
endmodule

bind dma_chan_seq dma_chan_seq_chk u_chk (.*);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] start_i = '0, stop_i = '0, clear_i = '0;
    logic [1:0] last_done_i = '0, outstanding_i = '0;
    logic [1:0] int_err_i = '0, ext_err_i = '0;
    logic [5:0] status_o;
    logic [1:0] run_en_o, halt_req_o, int_err_o, ext_err_o;

    int checks = 0;
    int errors = 0;

    localparam int IDLE = 0, QUE = 1, RUN = 2, DONE = 3, FLT = 4;

    always #10 clk = ~clk;

    dma_chan_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .stop_i(stop_i), .clear_i(clear_i),
        .last_done_i(last_done_i), .outstanding_i(outstanding_i),
        .int_err_i(int_err_i), .ext_err_i(ext_err_i),
        .status_o(status_o), .run_en_o(run_en_o), .halt_req_o(halt_req_o),
        .int_err_o(int_err_o), .ext_err_o(ext_err_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int st(int ch);
        return int'(status_o[ch*3 +: 3]);
    endfunction

    task automatic clr_in();
        start_i = '0; stop_i = '0; clear_i = '0;
        last_done_i = '0; outstanding_i = '0;
        int_err_i = '0; ext_err_i = '0;
    endtask

    task automatic do_reset();
        clr_in();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic pulse(input logic [1:0] sa, input logic [1:0] so, input logic [1:0] sc);
        start_i = sa; stop_i = so; clear_i = sc;
        tick();
        start_i = '0; stop_i = '0; clear_i = '0;
    endtask

    // Put channel 0 into the requested state with channel 1 Idle (Running for QUE).
    task automatic setup0(int s);
        do_reset();
        case (s)
            QUE: begin
                outstanding_i[1] = 1'b1;
                pulse(2'b10, 2'b00, 2'b00);
                pulse(2'b01, 2'b00, 2'b00);
            end
            RUN: pulse(2'b01, 2'b00, 2'b00);
            DONE: begin
                pulse(2'b01, 2'b00, 2'b00);
                last_done_i[0] = 1'b1; tick(); last_done_i[0] = 1'b0;
            end
            FLT: begin
                pulse(2'b01, 2'b00, 2'b00);
                int_err_i[0] = 1'b1; tick(); int_err_i[0] = 1'b0;
                last_done_i[0] = 1'b1; tick(); last_done_i[0] = 1'b0;
            end
            default: ;
        endcase
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 reset status", int'(status_o), 0);
        chk("R1 reset run_en", int'(run_en_o), 0);
        chk("R1 reset halt", int'(halt_req_o), 0);
        chk("R1 reset faults", int'({int_err_o, ext_err_o}), 0);

        // R9/R2/R5/R6 sweep: every strobe mix from every channel-0 state
        for (int s = 0; s < 5; s++) begin
            for (int m = 0; m < 8; m++) begin
                int sel;
                int exp_st;
                int exp_halt;
                setup0(s);
                chk("R2 setup state", st(0), s);
                sel = m[2] ? 3 : (m[1] ? 2 : (m[0] ? 1 : 0)); // 3 clear, 2 stop, 1 start
                pulse({1'b0, m[0]}, {1'b0, m[1]}, {1'b0, m[2]});
                exp_st = s;
                exp_halt = 0;
                if (s == IDLE && sel == 1) exp_st = RUN;
                if (s == QUE && sel == 2) exp_st = IDLE;
                if (s == RUN && sel == 2) exp_halt = 1;
                if ((s == DONE || s == FLT) && sel == 3) exp_st = IDLE;
                chk($sformatf("R9 sweep st%0d m%0d status", s, m), st(0), exp_st);
                chk($sformatf("R4 sweep st%0d m%0d halt", s, m), int'(halt_req_o[0]), exp_halt);
                if (s == FLT && sel == 3)
                    chk("R6 clear resets fault", int'(int_err_o[0]), 0);
            end
        end

        // R4 stop drains outstanding accesses before leaving Running
        do_reset();
        outstanding_i[0] = 1'b1;
        pulse(2'b01, 2'b00, 2'b00);
        chk("R4 run_en before stop", int'(run_en_o[0]), 1);
        pulse(2'b00, 2'b01, 2'b00);
        chk("R4 run_en after stop", int'(run_en_o[0]), 0);
        tick(); tick();
        chk("R4 stays Running while draining", st(0), RUN);
        outstanding_i[0] = 1'b0;
        tick();
        chk("R4 Complete after drain", st(0), DONE);
        chk("R4 halt released", int'(halt_req_o[0]), 0);

        // R7/R3 external fault, faulted channel blocks the other
        do_reset();
        pulse(2'b01, 2'b00, 2'b00);
        ext_err_i[0] = 1'b1; tick(); ext_err_i[0] = 1'b0;
        chk("R7 sticky ext flag", int'(ext_err_o[0]), 1);
        last_done_i[0] = 1'b1; tick(); last_done_i[0] = 1'b0;
        chk("R7 finish as Error", st(0), FLT);
        chk("R7 int flag untouched", int'(int_err_o[0]), 0);
        pulse(2'b10, 2'b00, 2'b00);
        chk("R3 faulted channel in operation", st(1), QUE);
        pulse(2'b00, 2'b00, 2'b01);
        chk("R8 cleared, not yet promoted", st(1), QUE);
        tick();
        chk("R8 promoted one cycle later", st(1), RUN);

        // R8 tie on simultaneous starts
        do_reset();
        pulse(2'b11, 2'b00, 2'b00);
        chk("R8 tie ch0", st(0), RUN);
        chk("R8 tie ch1", st(1), QUE);
        last_done_i[0] = 1'b1; tick(); last_done_i[0] = 1'b0;
        chk("R7 clean Complete", st(0), DONE);
        chk("R8 promotion edge wait", st(1), QUE);
        tick();
        chk("R8 promoted after Complete", st(1), RUN);

        // R3 clean Complete does not block the other channel
        do_reset();
        pulse(2'b01, 2'b00, 2'b00);
        last_done_i[0] = 1'b1; tick(); last_done_i[0] = 1'b0;
        pulse(2'b10, 2'b00, 2'b00);
        chk("R3 start beside clean Complete", st(1), RUN);
        chk("R3 ch0 still Complete", st(0), DONE);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule